// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block sits between a serial receiver front end and the host read path of a serial port. It holds up to four received bytes and always presents the oldest one on its head output. Each host pop removes that byte, and the remaining bytes move one place toward the head. The queue keeps two flags: a ready flag that says data is waiting and a full flag that says all four slots are taken. It also drives an accept signal that tells the front end whether it may deliver a byte.

A line-break event from the front end places a zero byte in the queue and raises a sticky break-change flag. A control block clears that flag with a one-cycle pulse. When the queue is already full, the break byte overwrites the newest entry, so the break is never lost. A flush empties the queue and turns reception off. Separate one-cycle pulses turn reception on and off.

Top module: `rx_hold_fifo`

## Requirements
- R1: The queue holds at most four 8-bit entries. `head_byte` shows the oldest entry, and each pop moves the remaining entries one place toward the head, in arrival order. `head_byte` reads 0x00 while the queue is empty.
- R2: `accept` is high exactly when reception is on and `rx_full` is low. A `push_vld` while `accept` is low is ignored.
- R3: A `brk_evt` sets `dbrk` and enqueues 0x00, whether or not reception is on. If four entries are already held, the 0x00 replaces the newest entry and the count stays at four. If `push_vld` arrives in the same cycle as a break, the pushed byte is dropped.
- R4: Every enqueue sets `rx_rdy`. `rx_full` is set when the count reaches four.
- R5: A pop on an empty queue changes no entry and no flag, and `head_byte` stays 0x00.
- R6: A pop always clears `rx_full`. It clears `rx_rdy` only when the queue becomes empty.
- R7: `flush_req` empties the queue, clears `rx_rdy` and `rx_full`, and turns reception off. It overrides a push, the queue write of a break, and `rcv_on` in the same cycle.
- R8: When a pop and an enqueue happen in the same cycle, the pop is applied first and the enqueue second. The flags reflect the resulting occupancy.
- R9: `dbrk` stays set until a `dbrk_clr` pulse. When a clear and a break arrive in the same cycle, `dbrk` stays set.
- R10: While `rst_n` is low at a clock edge, the queue empties and `rx_rdy`, `rx_full` and `dbrk` clear. Reception turns off.
- R11: `rcv_on` turns reception on and `rcv_off` turns it off. If both arrive in the same cycle, reception ends up off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_vld | input | 1 | Front end delivers `push_byte` this cycle |
| push_byte | input | 8 | Received byte |
| brk_evt | input | 1 | Break detected on the line |
| pop_req | input | 1 | Host consumes the head byte |
| flush_req | input | 1 | Receiver reset: empty the queue and turn reception off |
| dbrk_clr | input | 1 | Clear the break-change flag |
| rcv_on | input | 1 | Turn reception on |
| rcv_off | input | 1 | Turn reception off |
| head_byte | output | 8 | Oldest held byte, 0x00 when empty |
| rx_rdy | output | 1 | At least one byte is held |
| rx_full | output | 1 | Four bytes are held |
| dbrk | output | 1 | Sticky break-change flag |
| accept | output | 1 | Front end may deliver a byte |

## Verification
The bench fills the queue and then sends a break. A design that drops the break byte, or that appends it beyond the fourth slot, shows the wrong head sequence on the pops that follow. The bench pops from a full queue and checks that `rx_full` falls while `rx_rdy` stays high, which catches a design that ties both flags to the same condition. It pops and pushes in the same cycle, on a single-entry queue and on a full queue, where applying the operations in the wrong order either loses a byte or leaves the full flag wrong. It also sends a flush together with a push and a clear together with a break. A design that orders these pairs the wrong way ends up with stray data, with reception left on, or with a break-change flag that was silently lost.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Shared types for the receive holding queue. The operation bundle is the
// already-qualified per-cycle command that the control unit sends to the
// storage and flag units.
package rxq_pkg;

    typedef struct packed {
        logic wr;     // enqueue this cycle (data byte or break byte)
        logic pop;    // remove head this cycle (queue known non-empty)
        logic flush;  // empty the queue
    } rxq_op_t;

endpackage

// File: rtl/rxq_ctrl.sv
// Module rxq_ctrl
// Qualifies the raw requests into one operation bundle. It also owns the
// reception-enable state and the sticky break-change flag.
// Assumes: request inputs are single-cycle and synchronous to clk.
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_vld,
    input  logic [WIDTH-1:0] push_byte,
    input  logic             brk_evt,
    input  logic             pop_req,
    input  logic             flush_req,
    input  logic             dbrk_clr,
    input  logic             rcv_on,
    input  logic             rcv_off,
    input  logic [CW-1:0]    cnt,
    input  logic             full,
    output rxq_op_t          op,
    output logic [WIDTH-1:0] wdata,
    output logic             accept,
    output logic             rcv_en,
    output logic             dbrk
);

    // Front end handshake: open only while reception is on and space remains.
    always_comb begin
        accept = rcv_en & ~full;
    end

    // Build the qualified operation; a break takes the write slot over a push.
    always_comb begin
        op.flush = flush_req;
        op.pop   = pop_req & (cnt != '0) & ~flush_req;
        op.wr    = ~flush_req & (brk_evt | (push_vld & accept));
        wdata    = brk_evt ? '0 : push_byte;
    end

    // Reception enable: flush and off dominate on.
    always_ff @(posedge clk) begin
        if (!rst_n)          rcv_en <= 1'b0;
        else if (flush_req)  rcv_en <= 1'b0;
        else if (rcv_off)    rcv_en <= 1'b0;
        else if (rcv_on)     rcv_en <= 1'b1;
    end

    // Sticky break-change flag: a new break beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        dbrk <= 1'b0;
        else if (brk_evt)  dbrk <= 1'b1;
        else if (dbrk_clr) dbrk <= 1'b0;
    end

    assert_break_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> dbrk);
    assert_clear_drops_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbrk_clr && !brk_evt) |=> !dbrk);
    assert_flush_stops_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !rcv_en);
    assert_off_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_off |=> !rcv_en);

endmodule

// File: rtl/rxq_store.sv
// Module rxq_store
// Shift-register storage with an occupancy count. Slot 0 is always the head.
// A pop shifts every slot toward the head. The pop is applied before a
// write in the same cycle. A write into a full queue overwrites the last
// slot.
// Assumes: op.pop is only raised when the count is non-zero.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxq_op_t          op,
    input  logic [WIDTH-1:0] wdata,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    nxt_cnt,
    output logic [WIDTH-1:0] head
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] slot     [DEPTH];
    logic [WIDTH-1:0] shifted  [DEPTH];
    logic [WIDTH-1:0] slot_d   [DEPTH];
    logic [CW-1:0]    cnt_popped;
    logic [CW-1:0]    wr_idx;

    // Occupancy after the pop, then the slot the write lands in.
    always_comb begin
        cnt_popped = op.pop ? cnt - 1'b1 : cnt;
        wr_idx     = (cnt_popped == FULL_CNT) ? FULL_CNT - 1'b1 : cnt_popped;
        if (op.flush)
            nxt_cnt = '0;
        else if (op.wr && cnt_popped != FULL_CNT)
            nxt_cnt = cnt_popped + 1'b1;
        else
            nxt_cnt = cnt_popped;
    end

    // Per-slot next value: shift on pop, then optional write.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_mid
            always_comb shifted[i] = op.pop ? slot[i+1] : slot[i];
        end else begin : g_last
            always_comb shifted[i] = op.pop ? '0 : slot[i];
        end

        always_comb begin
            slot_d[i] = (op.wr && wr_idx == CW'(i)) ? wdata : shifted[i];
        end

        // Slot register.
        always_ff @(posedge clk) begin
            if (!rst_n) slot[i] <= '0;
            else        slot[i] <= slot_d[i];
        end
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt_cnt;
    end

    // Head presentation: zero when nothing is held.
    always_comb begin
        head = (cnt != '0) ? slot[0] : '0;
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    assert_shift_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op.pop && !op.wr && !op.flush && cnt > CW'(1)) |=> head == $past(slot[1]));
    assert_full_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op.wr && !op.pop && !op.flush && cnt == FULL_CNT) |=> cnt == FULL_CNT);

endmodule

// File: rtl/rxq_flags.sv
// Module rxq_flags
// Receive-ready and full flags, registered from the operation and the next
// occupancy. Ready is set by any write and cleared only on draining. Full is
// cleared by any pop and set when a write leaves the queue at depth.
// Assumes: nxt_cnt already reflects pop-before-write ordering.
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rxq_op_t       op,
    input  logic [CW-1:0] nxt_cnt,
    output logic          rdy,
    output logic          full
);

    logic rdy_d;
    logic full_d;

    // Next flag values in priority order: pop, then write, then flush.
    always_comb begin
        rdy_d  = rdy;
        full_d = full;
        if (op.pop) begin
            full_d = 1'b0;
            if (nxt_cnt == '0) rdy_d = 1'b0;
        end
        if (op.wr) begin
            rdy_d = 1'b1;
            if (nxt_cnt == CW'(DEPTH)) full_d = 1'b1;
        end
        if (op.flush) begin
            rdy_d  = 1'b0;
            full_d = 1'b0;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy  <= 1'b0;
            full <= 1'b0;
        end else begin
            rdy  <= rdy_d;
            full <= full_d;
        end
    end

    assert_pop_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op.pop && !op.wr) |=> !full);
    assert_write_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op.wr && !op.flush) |=> rdy);

endmodule

// File: rtl/rx_hold_fifo.sv
// Module rx_hold_fifo
// Four-entry receive holding queue with break-byte insertion, sticky
// break-change flag, ready/full flags and front-end accept.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module rx_hold_fifo
    import rxq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_vld,
    input  logic [WIDTH-1:0] push_byte,
    input  logic             brk_evt,
    input  logic             pop_req,
    input  logic             flush_req,
    input  logic             dbrk_clr,
    input  logic             rcv_on,
    input  logic             rcv_off,
    output logic [WIDTH-1:0] head_byte,
    output logic             rx_rdy,
    output logic             rx_full,
    output logic             dbrk,
    output logic             accept
);

    localparam int CW = $clog2(DEPTH + 1);

    rxq_op_t          op;
    logic [WIDTH-1:0] wdata;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    nxt_cnt;
    logic             rcv_en;

    rxq_ctrl #(.WIDTH(WIDTH), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_vld  (push_vld),
        .push_byte (push_byte),
        .brk_evt   (brk_evt),
        .pop_req   (pop_req),
        .flush_req (flush_req),
        .dbrk_clr  (dbrk_clr),
        .rcv_on    (rcv_on),
        .rcv_off   (rcv_off),
        .cnt       (cnt),
        .full      (rx_full),
        .op        (op),
        .wdata     (wdata),
        .accept    (accept),
        .rcv_en    (rcv_en),
        .dbrk      (dbrk)
    );

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wdata   (wdata),
        .cnt     (cnt),
        .nxt_cnt (nxt_cnt),
        .head    (head_byte)
    );

    rxq_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .nxt_cnt (nxt_cnt),
        .rdy     (rx_rdy),
        .full    (rx_full)
    );

    assert_ready_tracks_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy == (cnt != '0));
    assert_full_tracks_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full == (cnt == CW'(DEPTH)));
    assert_refused_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && !accept && !brk_evt && !pop_req && !flush_req) |=> $stable(cnt));
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt == '0 && !op.wr) |=> (cnt == '0 && head_byte == '0));
    assert_pop_then_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op.pop && op.wr) |=> cnt == $past(cnt));
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (cnt == '0 && !rx_rdy && !rx_full));
    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !dbrk && !rcv_en && !rx_rdy));

endmodule

// File: tb/tb_rx_hold_fifo.sv
`timescale 1ns/1ps
module tb_rx_hold_fifo;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       push_vld, brk_evt, pop_req, flush_req, dbrk_clr, rcv_on, rcv_off;
    logic [7:0] push_byte;
    logic [7:0] head_byte;
    logic       rx_rdy, rx_full, dbrk, accept;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rx_hold_fifo dut (
        .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_byte(push_byte),
        .brk_evt(brk_evt), .pop_req(pop_req), .flush_req(flush_req),
        .dbrk_clr(dbrk_clr), .rcv_on(rcv_on), .rcv_off(rcv_off),
        .head_byte(head_byte), .rx_rdy(rx_rdy), .rx_full(rx_full),
        .dbrk(dbrk), .accept(accept)
    );

    // Vector: {0, push, byte, brk, pop, flush, clr, on, off, head, rdy, full, dbrk, accept, req}
    function automatic logic [31:0] mk(bit pv, logic [7:0] pb, bit bk, bit pp, bit fl,
                                       bit cl, bit on, bit off, logic [7:0] eh,
                                       bit er, bit ef, bit ed, bit ea, int rq);
        return {1'b0, pv, pb, bk, pp, fl, cl, on, off, eh, er, ef, ed, ea, 4'(rq)};
    endfunction

    localparam int NV = 31;
    localparam logic [31:0] VT [NV] = '{
        mk(0,8'h00,0,0,0,0,1,0, 8'h00,0,0,0,1, 11), // R11 turn reception on
        mk(1,8'hA1,0,0,0,0,0,0, 8'hA1,1,0,0,1, 4),  // R4 first push sets ready
        mk(1,8'hB2,0,0,0,0,0,0, 8'hA1,1,0,0,1, 1),  // R1 head keeps oldest
        mk(1,8'hC3,0,0,0,0,0,0, 8'hA1,1,0,0,1, 1),  // R1
        mk(1,8'hD4,0,0,0,0,0,0, 8'hA1,1,1,0,0, 4),  // R4 fourth push sets full
        mk(1,8'hE5,0,0,0,0,0,0, 8'hA1,1,1,0,0, 2),  // R2 refused while full
        mk(0,8'h00,1,0,0,0,0,0, 8'hA1,1,1,1,0, 3),  // R3 break overwrites newest
        mk(0,8'h00,0,1,0,0,0,0, 8'hB2,1,0,1,1, 6),  // R6 pop clears full only
        mk(0,8'h00,0,1,0,0,0,0, 8'hC3,1,0,1,1, 1),  // R1 shift
        mk(0,8'h00,0,1,0,0,0,0, 8'h00,1,0,1,1, 3),  // R3 break byte replaced D4
        mk(1,8'h77,0,1,0,0,0,0, 8'h77,1,0,1,1, 8),  // R8 pop then push
        mk(0,8'h00,0,1,0,0,0,0, 8'h00,0,0,1,1, 6),  // R6 drain clears ready
        mk(0,8'h00,0,1,0,0,0,0, 8'h00,0,0,1,1, 5),  // R5 pop on empty
        mk(0,8'h00,0,0,0,1,0,0, 8'h00,0,0,0,1, 9),  // R9 clear
        mk(0,8'h00,1,0,0,1,0,0, 8'h00,1,0,1,1, 9),  // R9 break beats clear
        mk(0,8'h00,0,0,0,1,0,0, 8'h00,1,0,0,1, 9),  // R9
        mk(0,8'h00,0,1,0,0,0,0, 8'h00,0,0,0,1, 6),  // R6
        mk(0,8'h00,0,0,0,0,0,1, 8'h00,0,0,0,0, 11), // R11 off
        mk(1,8'h55,0,0,0,0,0,0, 8'h00,0,0,0,0, 2),  // R2 push ignored when off
        mk(0,8'h00,1,0,0,0,0,0, 8'h00,1,0,1,0, 3),  // R3 break while off
        mk(0,8'h00,0,0,0,0,1,1, 8'h00,1,0,1,0, 11), // R11 off wins
        mk(0,8'h00,0,0,0,0,1,0, 8'h00,1,0,1,1, 11), // R11
        mk(1,8'h66,0,0,0,0,0,0, 8'h00,1,0,1,1, 1),  // R1
        mk(1,8'h99,0,0,1,0,0,0, 8'h00,0,0,1,0, 7),  // R7 flush beats push
        mk(0,8'h00,0,0,0,1,1,0, 8'h00,0,0,0,1, 11), // R11
        mk(1,8'h11,1,0,0,0,0,0, 8'h00,1,0,1,1, 3),  // R3 push dropped under break
        mk(1,8'h22,0,0,0,0,0,0, 8'h00,1,0,1,1, 1),  // R1
        mk(1,8'h33,0,0,0,0,0,0, 8'h00,1,0,1,1, 1),  // R1
        mk(1,8'h44,0,0,0,0,0,0, 8'h00,1,1,1,0, 4),  // R4
        mk(0,8'h00,1,1,0,0,0,0, 8'h22,1,1,1,0, 8),  // R8 pop then break at full
        mk(0,8'h00,0,1,0,0,0,0, 8'h33,1,0,1,1, 6)   // R6
    };

    task automatic idle();
        push_vld = 0; push_byte = '0; brk_evt = 0; pop_req = 0;
        flush_req = 0; dbrk_clr = 0; rcv_on = 0; rcv_off = 0;
    endtask

    task automatic check(string rq, logic [11:0] act, logic [11:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {head,rdy,full,dbrk,accept} actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {head_byte, rx_rdy, rx_full, dbrk, accept};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state", outs(), 12'h000);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VT[i];
            @(negedge clk);
            {push_vld, push_byte, brk_evt, pop_req, flush_req, dbrk_clr, rcv_on, rcv_off} = v[30:16];
            @(posedge clk);
            #1;
            check($sformatf("R%0d vector %0d", v[3:0], i), outs(), v[15:4]);
        end

        // R7: flush together with rcv_on leaves reception off.
        @(negedge clk) begin idle(); flush_req = 1; rcv_on = 1; end
        @(posedge clk); #1;
        check("R7 flush beats rcv_on", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b0});

        // R10: reset in mid-operation with data held and break flag set.
        @(negedge clk) begin idle(); rcv_on = 1; end
        @(negedge clk) begin idle(); push_vld = 1; push_byte = 8'h5A; end
        @(posedge clk); #1;
        check("R10 preload", outs(), {8'h5A, 1'b1, 1'b0, 1'b1, 1'b1});
        @(negedge clk) begin idle(); rst_n = 0; end
        @(posedge clk); #1;
        check("R10 reset clears all", outs(), 12'h000);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1;
        check("R10 stays clear after reset", outs(), 12'h000);

        finish_run();
    end

endmodule